// File: doc/BRIEF.md
# Triangular Spread-Spectrum Divider Sequencer

This block produces the per-cycle divider word for a fractional feedback divider in a clock synthesizer, so that the synthesized frequency sweeps in a symmetric triangle around a nominal ratio. One modulation period lasts a programmed number of clock pulses. That count can be set equal to the pixel count of a video line, which ties the sweep to the raster and keeps it from drifting across the screen. In the first half of each period the offset climbs in equal steps. In the second half it falls back by the same number of equal steps, so the offset lands exactly where it started at every period boundary.

Software supplies three words. The period length gives the pulses per period and must be even. The nominal divider word is the integer ratio around which the sweep is centred. The amplitude word is written as half the period count plus an excess, and that excess sets the deviation. When modulation is enabled (active-low), the block captures the configuration and computes a fixed per-step increment with a short sequential division. It then runs the ramp. The output word carries `FRAC_W` fractional bits and swings between nominal minus the peak deviation and nominal plus the peak deviation. Each period starts at the trough. A one-cycle marker flags the start of every period. An odd or zero period length is refused and reported on a sticky flag.

Top module: `ssm_seq`

## Requirements
- R1: After reset `div_word` is 0 and both `cycle_mark` and `cfg_err` are low. While idle with `ss_en_n` high, `div_word` equals `cfg_mod`·2^FRAC_W one edge after the inputs are sampled, and `cycle_mark` stays low.
- R2: While modulating, `cycle_mark` is high for exactly one cycle every NC cycles, at phase 0.
- R3: At phase p (0..NC−1) of a period, `div_word` = nominal + 2·a(p) − P, with a(p) = p·inc for p ≤ NC/2 and (NC−p)·inc otherwise. At phase 0 the accumulated offset is zero, so the output is nominal − P.
- R4: inc = floor(amp·2^FRAC_W / (NC/2)) and P = inc·NC/2. At phase NC/2 the output peaks at nominal + P.
- R5: amp = NSS − NC/2 when NSS > NC/2, and 0 otherwise. A zero amplitude gives a flat nominal output while the period markers continue.
- R6: An odd or zero NC holds `div_word` at nominal with no markers and sets `cfg_err`. `cfg_err` stays set until reset, through later disables and legal runs.
- R7: The configuration inputs are captured at every rising edge in the idle state, including the edge that first samples `ss_en_n` low. Changes at any other time, including odd NC values, have no effect until the block is idle again.
- R8: Once `ss_en_n` is sampled high during modulation, the current period completes on profile. On the cycle after its last phase the output returns to the nominal word that was in use and the markers stop.
- R9: After enabling, the output stays at nominal until the first marker. The first marker appears no more than NSS_W+FRAC_W+4 cycles after the first edge that samples `ss_en_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one modulation step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_en_n | input | 1 | Active-low modulation enable |
| cfg_nc | input | NC_W | Pulses per modulation period (even, nonzero) |
| cfg_mod | input | MOD_W | Nominal integer divider ratio |
| cfg_nss | input | NSS_W | Amplitude word: NC/2 plus the deviation excess |
| div_word | output | OUT_W | Signed divider word with FRAC_W fractional bits |
| cycle_mark | output | 1 | One-cycle pulse at phase 0 of each period |
| cfg_err | output | 1 | Sticky flag: an illegal period length was enabled |

## Verification
The bench aims at the extremes of the ramp arithmetic. With NC=2 and a full-scale amplitude the increment fills the whole quotient, and with a zero nominal the trough goes negative. A design that lost the sign or truncated the quotient would show a wrong trough or peak value. NC=2046 with maximum amplitude tests the remainder handling of the division: a design that rounded the increment differently would miss the exact peak P or fail to return to zero at the boundary. Odd and zero period lengths must produce no markers and a sticky flag, and a design that modulated anyway would emit markers. During modulation the bench scrambles the configuration inputs, including odd lengths, and it drops the enable at the very last phase and at mid-period phases. A design that sampled the configuration late, or stopped mid-ramp, would step off the expected profile or return to the wrong nominal word.

// File: rtl/ssm_pkg.sv
// Shared types for the spread-spectrum sequencer.
// Assumes: nothing beyond SystemVerilog-2017 enum support.
package ssm_pkg;

    // Control states of the sequencer.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,   // disabled, configuration tracks inputs
        S_START = 3'd1,   // configuration frozen, legality decided
        S_DIV   = 3'd2,   // per-step increment being divided out
        S_RAMP  = 3'd3,   // triangle running
        S_FAULT = 3'd4    // illegal period length, holding nominal
    } ssm_state_e;

endpackage

// File: rtl/ssm_cfg.sv
// Configuration capture and decode.
// What it does: holds the three configuration words and derives the
// half period, the legality of the period and the amplitude excess.
// Assumes: load is high only while the sequencer is idle.
module ssm_cfg #(
    parameter int NC_W  = 11,
    parameter int MOD_W = 13,
    parameter int NSS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NC_W-1:0]   cfg_nc,
    input  logic [MOD_W-1:0]  cfg_mod,
    input  logic [NSS_W-1:0]  cfg_nss,
    output logic [NC_W-1:0]   nc_q,
    output logic [MOD_W-1:0]  mod_q,
    output logic [NSS_W-1:0]  nss_q,
    output logic [NC_W-2:0]   half,
    output logic [NSS_W-1:0]  amp,
    output logic              legal
);
    localparam int CW = ((NSS_W > NC_W) ? NSS_W : NC_W) + 1;

    logic [CW-1:0] nss_x;
    logic [CW-1:0] half_x;

    // Capture the configuration words while loading is permitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nc_q  <= '0;
            mod_q <= '0;
            nss_q <= '0;
        end else if (load) begin
            nc_q  <= cfg_nc;
            mod_q <= cfg_mod;
            nss_q <= cfg_nss;
        end
    end

    // Derive the half period, the legality and the clamped amplitude excess.
    always_comb begin
        half   = nc_q[NC_W-1:1];
        legal  = (nc_q != '0) && !nc_q[0];
        nss_x  = CW'(nss_q);
        half_x = CW'(half);
        amp    = (nss_x > half_x) ? NSS_W'(nss_x - half_x) : '0;
    end

endmodule

// File: rtl/ssm_div.sv
// Sequential restoring divider.
// What it does: divides a DW-bit dividend by a VW-bit divisor, one
// quotient bit per cycle, MSB first, and pulses done for one cycle
// with quotient and remainder valid.
// Assumes: divisor is nonzero and stable while busy; start restarts.
module ssm_div #(
    parameter int DW = 23,
    parameter int VW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [DW-1:0]  dividend,
    input  logic [VW-1:0]  divisor,
    output logic           done,
    output logic [DW-1:0]  quot,
    output logic [VW-1:0]  rem
);
    localparam int CNT_W = $clog2(DW + 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [VW-1:0]    rem_q;
    logic [DW-1:0]    quo_q;
    logic [VW:0]      trial;
    logic [VW:0]      diff;
    logic             ge;

    // Form the trial remainder and decide the next quotient bit.
    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        ge    = (trial >= {1'b0, divisor});
        diff  = trial - {1'b0, divisor};
    end

    // Iterate one bit per cycle; flag completion after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                rem_q  <= '0;
                quo_q  <= dividend;
            end else if (busy_q) begin
                rem_q <= ge ? diff[VW-1:0] : trial[VW-1:0];
                quo_q <= {quo_q[DW-2:0], ge};
                if (cnt_q == CNT_W'(DW - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign done = done_q;
    assign quot = quo_q;
    assign rem  = rem_q;

endmodule

// File: rtl/ssm_ramp.sv
// Phase counter and triangle accumulator.
// What it does: while run is high, steps the phase from 0 to nc-1 and
// wraps; adds inc below half, subtracts it from half onward.
// Assumes: nc is even and nonzero while running; both registers clear
// whenever run is low, so every run begins at phase 0 with a zero sum.
module ssm_ramp #(
    parameter int NC_W = 11,
    parameter int AW   = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NC_W-1:0]  nc,
    input  logic [NC_W-2:0]  half,
    input  logic [AW-1:0]    inc,
    output logic [NC_W-1:0]  phase,
    output logic [AW-1:0]    acc,
    output logic             wrap
);
    logic [NC_W-1:0] phase_q;
    logic [AW-1:0]   acc_q;
    logic            rising;

    // Detect the last phase and the direction of the current step.
    always_comb begin
        wrap   = run && (phase_q == (nc - NC_W'(1)));
        rising = (phase_q < {1'b0, half});
    end

    // Advance the phase and the accumulated offset one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            acc_q   <= '0;
        end else if (!run) begin
            phase_q <= '0;
            acc_q   <= '0;
        end else begin
            phase_q <= wrap ? '0 : phase_q + NC_W'(1);
            acc_q   <= rising ? acc_q + inc : acc_q - inc;
        end
    end

    assign phase = phase_q;
    assign acc   = acc_q;

endmodule

// File: rtl/ssm_seq.sv
// Triangular spread-spectrum divider sequencer, top level.
// What it does: captures configuration while idle, checks the period,
// divides out the per-step increment, runs a triangle whose trough sits
// at each period boundary and emits nominal + 2*acc - peak.
// Assumes: single clock; synchronous active-low reset; FRAC_W fractional
// bits on the output word.
module ssm_seq
    import ssm_pkg::*;
#(
    parameter int NC_W   = 11,
    parameter int MOD_W  = 13,
    parameter int NSS_W  = 11,
    parameter int FRAC_W = 12,
    localparam int OUT_W = ((MOD_W > NSS_W + 1) ? MOD_W : NSS_W + 1) + FRAC_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ss_en_n,
    input  logic [NC_W-1:0]          cfg_nc,
    input  logic [MOD_W-1:0]         cfg_mod,
    input  logic [NSS_W-1:0]         cfg_nss,
    output logic signed [OUT_W-1:0]  div_word,
    output logic                     cycle_mark,
    output logic                     cfg_err
);
    localparam int DW = NSS_W + FRAC_W;
    localparam int HW = NC_W - 1;

    ssm_state_e      st_q;
    ssm_state_e      st_nx;
    logic            stop_q;
    logic            err_q;
    logic [DW-1:0]   inc_q;
    logic [DW-1:0]   pk_q;

    logic [NC_W-1:0]  nc_q;
    logic [MOD_W-1:0] mod_q;
    logic [NSS_W-1:0] nss_q;
    logic [HW-1:0]    half;
    logic [NSS_W-1:0] amp;
    logic             legal;

    logic [DW-1:0]   dividend;
    logic            div_done;
    logic [DW-1:0]   quot;
    logic [HW-1:0]   rem;

    logic            run;
    logic [NC_W-1:0] phase;
    logic [DW-1:0]   acc;
    logic            wrap;

    logic [OUT_W-1:0] base_w;
    logic [OUT_W-1:0] off_w;

    ssm_cfg #(
        .NC_W  (NC_W),
        .MOD_W (MOD_W),
        .NSS_W (NSS_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (st_q == S_IDLE),
        .cfg_nc  (cfg_nc),
        .cfg_mod (cfg_mod),
        .cfg_nss (cfg_nss),
        .nc_q    (nc_q),
        .mod_q   (mod_q),
        .nss_q   (nss_q),
        .half    (half),
        .amp     (amp),
        .legal   (legal)
    );

    assign dividend = {amp, {FRAC_W{1'b0}}};

    ssm_div #(
        .DW (DW),
        .VW (HW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    ((st_q == S_START) && legal),
        .dividend (dividend),
        .divisor  (half),
        .done     (div_done),
        .quot     (quot),
        .rem      (rem)
    );

    assign run = (st_q == S_RAMP);

    ssm_ramp #(
        .NC_W (NC_W),
        .AW   (DW)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .nc    (nc_q),
        .half  (half),
        .inc   (inc_q),
        .phase (phase),
        .acc   (acc),
        .wrap  (wrap)
    );

    // Choose the next control state from enable, legality and ramp events.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE:  if (!ss_en_n) st_nx = S_START;
            S_START: st_nx = legal ? S_DIV : S_FAULT;
            S_DIV: begin
                if (ss_en_n)       st_nx = S_IDLE;
                else if (div_done) st_nx = S_RAMP;
            end
            S_RAMP:  if (wrap && (stop_q || ss_en_n)) st_nx = S_IDLE;
            S_FAULT: if (ss_en_n) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // Hold the state, the pending stop request and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            stop_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_nx;
            stop_q <= (st_nx == S_RAMP) && (stop_q || (run && ss_en_n));
            if ((st_q == S_START) && !legal) err_q <= 1'b1;
        end
    end

    // Latch the step increment and the exact peak when the division ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
            pk_q  <= '0;
        end else if ((st_q == S_DIV) && div_done) begin
            inc_q <= quot;
            pk_q  <= dividend - DW'(rem);
        end
    end

    // Assemble the output word around the nominal ratio.
    always_comb begin
        base_w = OUT_W'({mod_q, {FRAC_W{1'b0}}});
        off_w  = (OUT_W'(acc) << 1) - OUT_W'(pk_q);
        div_word = run ? signed'(base_w + off_w) : signed'(base_w);
    end

    assign cycle_mark = run && (phase == '0);
    assign cfg_err    = err_q;

endmodule

// File: rtl/ssm_seq_chk.sv
// Temporal checks for ssm_seq, attached by bind.
// What it does: watches state, ramp and configuration registers.
// Assumes: synchronous active-low reset; all checks idle during reset.
module ssm_seq_chk
    import ssm_pkg::*;
#(
    parameter int NC_W  = 11,
    parameter int MOD_W = 13,
    parameter int NSS_W = 11,
    parameter int DW    = 23
) (
    input logic              clk,
    input logic              rst_n,
    input ssm_state_e        st,
    input logic              cycle_mark,
    input logic              cfg_err,
    input logic              wrap,
    input logic [NC_W-1:0]   phase,
    input logic [NC_W-1:0]   nc,
    input logic [MOD_W-1:0]  mod,
    input logic [NSS_W-1:0]  nss,
    input logic [DW-1:0]     acc,
    input logic [DW-1:0]     pk
);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r6_fault_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FAULT) |-> cfg_err);

    a_r2_mark_single: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_mark |=> !cycle_mark);

    a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RAMP) |-> (phase < nc));

    a_r3_zero_at_mark: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_mark |-> (acc == '0));

    a_r4_acc_within_peak: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RAMP) |-> (acc <= pk));

    a_r8_leave_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_RAMP) && !wrap) |=> (st == S_RAMP));

    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> ($stable(nc) && $stable(mod) && $stable(nss)));

endmodule

bind ssm_seq ssm_seq_chk #(
    .NC_W  (NC_W),
    .MOD_W (MOD_W),
    .NSS_W (NSS_W),
    .DW    (NSS_W + FRAC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st_q),
    .cycle_mark (cycle_mark),
    .cfg_err    (cfg_err),
    .wrap       (wrap),
    .phase      (phase),
    .nc         (nc_q),
    .mod        (mod_q),
    .nss        (nss_q),
    .acc        (acc),
    .pk         (pk_q)
);

// File: tb/sim_ssm_seq.sv
// Bench for ssm_seq: directed corners plus seeded random configurations,
// each compared cycle by cycle against a profile computed here.
module sim_ssm_seq;
    localparam int NC_W   = 11;
    localparam int MOD_W  = 13;
    localparam int NSS_W  = 11;
    localparam int FRAC_W = 12;
    localparam int OUT_W  = ((MOD_W > NSS_W + 1) ? MOD_W : NSS_W + 1) + FRAC_W + 2;
    localparam int DW     = NSS_W + FRAC_W;
    localparam time CLK_PER = 10ns;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    ss_en_n = 1'b1;
    logic [NC_W-1:0]         cfg_nc = '0;
    logic [MOD_W-1:0]        cfg_mod = '0;
    logic [NSS_W-1:0]        cfg_nss = '0;
    logic signed [OUT_W-1:0] div_word;
    logic                    cycle_mark;
    logic                    cfg_err;

    int n_chk = 0;
    int n_fail = 0;

    ssm_seq #(
        .NC_W   (NC_W),
        .MOD_W  (MOD_W),
        .NSS_W  (NSS_W),
        .FRAC_W (FRAC_W)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_en_n    (ss_en_n),
        .cfg_nc     (cfg_nc),
        .cfg_mod    (cfg_mod),
        .cfg_nss    (cfg_nss),
        .div_word   (div_word),
        .cycle_mark (cycle_mark),
        .cfg_err    (cfg_err)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic longint nominal(input longint md);
        return md <<< FRAC_W;
    endfunction

    // Expected output word at phase p for a legal configuration.
    function automatic longint exp_word(input longint nc, input longint md,
                                        input longint ns, input longint p);
        longint h, amp, inc, pk, a;
        h   = nc / 2;
        amp = (ns > h) ? ns - h : 0;
        inc = (amp <<< FRAC_W) / h;
        pk  = inc * h;
        a   = (p <= h) ? p * inc : (nc - p) * inc;
        return nominal(md) + 2 * a - pk;
    endfunction

    // One legal run: idle check, enable, several periods, stop, return.
    task automatic run_case(input int nc, input int md, input int ns,
                            input int periods, input int stop_ph);
        int cnt = 0;
        bit seen = 0;
        int smod;
        @(negedge clk);
        ss_en_n = 1'b1; cfg_nc = NC_W'(nc); cfg_mod = MOD_W'(md); cfg_nss = NSS_W'(ns);
        @(negedge clk);
        chk(longint'(div_word) == nominal(md), "R1 idle nominal", longint'(div_word), nominal(md));
        chk(cycle_mark == 1'b0, "R1 no mark idle", longint'(cycle_mark), 0);
        ss_en_n = 1'b0;
        while (!seen && cnt < DW + 8) begin
            @(negedge clk);
            cnt++;
            if (cycle_mark) seen = 1;
            else chk(longint'(div_word) == nominal(md), "R9 nominal before ramp",
                     longint'(div_word), nominal(md));
        end
        chk(seen && cnt <= DW + 4, "R9 first mark latency", cnt, DW + 4);
        if (!seen) return;
        // R7: scramble inputs, including an odd period, while modulating.
        cfg_nc  = NC_W'($urandom_range(0, (1 << NC_W) - 1) | 1);
        smod    = $urandom_range(0, (1 << MOD_W) - 1);
        cfg_mod = MOD_W'(smod);
        cfg_nss = NSS_W'($urandom_range(0, (1 << NSS_W) - 1));
        for (int idx = 0; idx < periods * nc; idx++) begin
            int p;
            longint e;
            string tag;
            p = idx % nc;
            e = exp_word(nc, md, ns, p);
            if (p == 0) tag = "R3 boundary trough";
            else if (p == nc / 2) tag = "R4 peak";
            else if (ns <= nc / 2) tag = "R5 flat profile";
            else tag = "R3 profile R7 frozen";
            chk(longint'(div_word) == e, tag, longint'(div_word), e);
            chk(cycle_mark == (p == 0), "R2 mark position", longint'(cycle_mark), longint'(p == 0));
            if (idx == (periods - 1) * nc + stop_ph) ss_en_n = 1'b1;
            @(negedge clk);
        end
        chk(longint'(div_word) == nominal(md) && !cycle_mark, "R8 return to nominal",
            longint'(div_word), nominal(md));
        @(negedge clk);
        chk(longint'(div_word) == nominal(smod), "R7 reload when idle",
            longint'(div_word), nominal(smod));
    endtask

    // An illegal period length: no modulation, sticky flag.
    task automatic run_bad(input int nc, input int md);
        @(negedge clk);
        ss_en_n = 1'b1; cfg_nc = NC_W'(nc); cfg_mod = MOD_W'(md); cfg_nss = NSS_W'(2047);
        @(negedge clk);
        ss_en_n = 1'b0;
        for (int i = 0; i < DW + 10; i++) begin
            @(negedge clk);
            chk(!cycle_mark && longint'(div_word) == nominal(md), "R6 illegal holds nominal",
                longint'(div_word), nominal(md));
        end
        chk(cfg_err == 1'b1, "R6 error raised", longint'(cfg_err), 1);
        ss_en_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cfg_err == 1'b1, "R6 error sticky", longint'(cfg_err), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(longint'(div_word) == 0 && !cycle_mark && !cfg_err, "R1 reset state",
            longint'(div_word), 0);
        rst_n = 1'b1;
        run_case(8, 100, 7, 3, 5);
        chk(cfg_err == 1'b0, "R6 no error on legal", longint'(cfg_err), 0);
        run_case(8, 100, 2, 2, 0);             // R5 amplitude clamps to zero
        run_case(8, 100, 4, 2, 7);             // R5 NSS equal to half
        run_case(2, 0, 2047, 4, 1);            // R3 negative trough, full quotient
        run_case(2046, 8191, 2047, 1, 2045);   // R4 largest period and amplitude
        run_case(640, 2000, 321, 2, 320);      // R8 stop at the peak
        run_bad(7, 55);                        // R6 odd period
        run_bad(0, 1234);                      // R6 zero period
        for (int k = 0; k < 12; k++) begin
            int nc, md, ns, per;
            nc  = 2 * $urandom_range(1, 150);
            md  = $urandom_range(0, (1 << MOD_W) - 1);
            ns  = $urandom_range(0, (1 << NSS_W) - 1);
            per = $urandom_range(1, 3);
            run_case(nc, md, ns, per, $urandom_range(0, nc - 1));
        end
        chk(cfg_err == 1'b1, "R6 error held through legal runs", longint'(cfg_err), 1);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule